// File: doc/BRIEF.md
# Greyscale Framebuffer Scan-out Expander

This block turns a packed 4-bit greyscale display memory into a magnified pixel stream for a video path. Each memory byte holds two horizontally adjacent pixels. The block fetches one byte at a time over a synchronous read port, splits it into its two grey levels, and sends every pixel four times in a row. Each source row is re-fetched for four consecutive output lines. With the default geometry, 64 displayed rows of 64 bytes become a 512 x 256 output frame.

Each grey level is widened to one of three colour packings: 15-bit (5:5:5), 16-bit (5:6:5) or 24-bit (8:8:8). The widening is done by bit replication, so black stays all zeros and full white stays all ones. A frame is produced only when a refresh-request flag is set. The `invalidate` input sets the flag, and the flag clears once the last pixel of a frame has been accepted. The output side uses a valid/ready handshake and carries start-of-frame and end-of-line markers.

Top module: `gs_scan_expander`

## Requirements
- R1: The byte for displayed row y and byte column x is read at address y*BYTES_PER_ROW + x. Read data is taken in the cycle after `mem_rd_en`. Rows at or beyond DISP_ROWS (for example rows 64..79 of the default 80-row memory) are never addressed.
- R2: Bits 7:4 of a byte give the left pixel of the pair and bits 3:0 give the right pixel.
- R3: Each pixel is sent HREP (4) times in a row, and each source row produces VREP (4) identical output lines. Rows are sent top to bottom and bytes left to right.
- R4: Format select values 2 and 3 give 24-bit output. Each of `pix_data[23:16]`, `[15:8]` and `[7:0]` equals {g,g}, where g is the 4-bit grey level.
- R5: Format select value 0 gives 15-bit output. `pix_data[14:10]`, `[9:5]` and `[4:0]` each equal n = 2g + (g>>3), and bits 23:15 are zero.
- R6: Format select value 1 gives 16-bit output. `pix_data[15:11]` and `[4:0]` equal n. `pix_data[10:5]` equals {n, n[4]}. Bits 23:16 are zero.
- R7: The format select is sampled once, when a frame starts. Changing it during a frame has no effect until the next frame.
- R8: After reset the refresh-request flag is clear, and no memory read and no pixel occur until `invalidate` is asserted.
- R9: The flag clears when the last pixel of a frame is accepted, so exactly one frame follows a request. A request made in the middle of a frame, and not on its final handshake, does not cause a further frame.
- R10: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data` and both markers hold their values. No pixel is dropped or repeated.
- R11: `pix_sof` is high only with the first pixel of a frame. `pix_eol` is high only with the last pixel of each output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| invalidate | input | 1 | Sets the refresh-request flag |
| fmt_sel | input | 2 | Output packing: 0 = 15-bit, 1 = 16-bit, 2 or 3 = 24-bit |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | 24 | Packed output pixel |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of an output line |

## Verification
The bound assertions check the following on every cycle: the output holds steady while stalled, no read address falls outside the displayed window, the markers appear only with a valid pixel, and every emitted pixel has the internal structure its latched format requires (channel equality and replicated bits). The pixel order, the nibble order, the replication counts, the marker positions and the exact grey values need the bench's reference stream. So do the sampling of the format at frame start and the one-frame-per-request behaviour of the flag, including a request made mid-frame.

// File: rtl/gs_scan_pkg.sv
// Shared types and constants for the greyscale scan-out expander.
package gs_scan_pkg;

    localparam int PIX_W = 24;

    // Output packing codes seen on fmt_sel
    localparam logic [1:0] FMT_RGB15 = 2'd0;
    localparam logic [1:0] FMT_RGB16 = 2'd1;

    // Scan sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_EMIT  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/gs_dirty_flag.sv
// Refresh-request flag.
// Set by invalidate and cleared by the sequencer's end-of-frame pulse.
// A set and a clear in the same cycle leave the flag set.
// Assumes frame_done is a single-cycle pulse.
module gs_dirty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic invalidate,
    input  logic frame_done,
    output logic dirty
);

    // Flag register: a set request has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (invalidate) begin
            dirty <= 1'b1;
        end else if (frame_done) begin
            dirty <= 1'b0;
        end
    end

endmodule

// File: rtl/gs_grey_fmt.sv
// Grey-level widener.
// Converts a 4-bit grey value into one of three packed colour formats by bit replication.
// Purely combinational. Unused upper bits are driven to zero.
module gs_grey_fmt
    import gs_scan_pkg::*;
(
    input  logic [3:0]       grey,
    input  logic [1:0]       fmt,
    output logic [PIX_W-1:0] pix
);

    logic [4:0] lvl5;
    logic [5:0] lvl6;
    logic [7:0] lvl8;

    // Channel widths derived from the grey level
    always_comb begin
        lvl5 = {grey, grey[3]};
        lvl6 = {lvl5, lvl5[4]};
        lvl8 = {grey, grey};
    end

    // Pack the channels according to the selected format
    always_comb begin
        unique case (fmt)
            FMT_RGB15: pix = {9'd0, lvl5, lvl5, lvl5};
            FMT_RGB16: pix = {8'd0, lvl5, lvl6, lvl5};
            default:   pix = {lvl8, lvl8, lvl8};
        endcase
    end

endmodule

// File: rtl/gs_scan_seq.sv
// Scan sequencer.
// Walks displayed rows, line repeats, bytes, nibbles and pixel repeats in that nesting.
// Fetches one byte per pair of pixels through a memory port with one cycle of read latency,
// and presents a nibble under a valid/ready handshake.
// Assumes mem data is valid in the cycle after the read strobe.
module gs_scan_seq
    import gs_scan_pkg::*;
#(
    parameter int DISP_ROWS     = 64,
    parameter int BYTES_PER_ROW = 64,
    parameter int HREP          = 4,
    parameter int VREP          = 4,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dirty,
    input  logic [1:0]        fmt_in,
    output logic [1:0]        fmt_q,
    output logic              frame_done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        nibble,
    output logic              sof,
    output logic              eol
);

    localparam int ROW_W = (DISP_ROWS > 1) ? $clog2(DISP_ROWS) : 1;
    localparam int COL_W = (BYTES_PER_ROW > 1) ? $clog2(BYTES_PER_ROW) : 1;
    localparam int HR_W  = (HREP > 1) ? $clog2(HREP) : 1;
    localparam int VR_W  = (VREP > 1) ? $clog2(VREP) : 1;

    seq_state_t       state_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [HR_W-1:0]  hrep_q;
    logic [VR_W-1:0]  vrep_q;
    logic             half_q;
    logic [7:0]       byte_q;

    logic fire, last_h, last_col, last_v, last_row;
    logic byte_done, line_done, frame_end;

    // Position decode and handshake events
    always_comb begin
        fire      = (state_q == SQ_EMIT) && out_ready;
        last_h    = (hrep_q == HR_W'(HREP - 1));
        last_col  = (col_q  == COL_W'(BYTES_PER_ROW - 1));
        last_v    = (vrep_q == VR_W'(VREP - 1));
        last_row  = (row_q  == ROW_W'(DISP_ROWS - 1));
        byte_done = fire && half_q && last_h;
        line_done = byte_done && last_col;
        frame_end = line_done && last_v && last_row;
    end

    // State register and frame-start format capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            fmt_q   <= 2'd0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (dirty) begin
                        state_q <= SQ_FETCH;
                        fmt_q   <= fmt_in;
                    end
                end
                SQ_FETCH: state_q <= SQ_WAIT;
                SQ_WAIT:  state_q <= SQ_EMIT;
                SQ_EMIT: begin
                    if (byte_done) begin
                        state_q <= frame_end ? SQ_IDLE : SQ_FETCH;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Byte capture one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= 8'd0;
        end else if (state_q == SQ_WAIT) begin
            byte_q <= rd_data;
        end
    end

    // Nested position counters advanced on each accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hrep_q <= '0;
            half_q <= 1'b0;
            col_q  <= '0;
            vrep_q <= '0;
            row_q  <= '0;
        end else if (fire) begin
            hrep_q <= last_h ? '0 : hrep_q + 1'b1;
            if (last_h) begin
                half_q <= ~half_q;
            end
            if (byte_done) begin
                col_q <= last_col ? '0 : col_q + 1'b1;
            end
            if (line_done) begin
                vrep_q <= last_v ? '0 : vrep_q + 1'b1;
            end
            if (line_done && last_v) begin
                row_q <= last_row ? '0 : row_q + 1'b1;
            end
        end
    end

    // Memory request and output presentation
    always_comb begin
        rd_en      = (state_q == SQ_FETCH);
        rd_addr    = ADDR_W'(row_q) * ADDR_W'(BYTES_PER_ROW) + ADDR_W'(col_q);
        out_valid  = (state_q == SQ_EMIT);
        nibble     = half_q ? byte_q[3:0] : byte_q[7:4];
        sof        = out_valid && (row_q == '0) && (vrep_q == '0) && (col_q == '0)
                     && !half_q && (hrep_q == '0);
        eol        = out_valid && last_col && half_q && last_h;
        frame_done = frame_end;
    end

endmodule

// File: rtl/gs_scan_expander.sv
// Greyscale framebuffer scan-out expander (top).
// Reads packed 4-bit pixels from display memory and streams a magnified, colour-packed image.
// Assumes a synchronous memory with one cycle of read latency, and that nothing else
// changes the memory rows being scanned in a way that matters within a frame.
module gs_scan_expander
    import gs_scan_pkg::*;
#(
    parameter int DISP_ROWS     = 64,
    parameter int MEM_ROWS      = 80,
    parameter int BYTES_PER_ROW = 64,
    parameter int HREP          = 4,
    parameter int VREP          = 4,
    localparam int ADDR_W       = $clog2(MEM_ROWS * BYTES_PER_ROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic [1:0]        fmt_sel,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data,
    output logic              pix_sof,
    output logic              pix_eol
);

    logic       dirty;
    logic       frame_done;
    logic [1:0] fmt_q;
    logic [3:0] nibble;

    gs_dirty_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (invalidate),
        .frame_done (frame_done),
        .dirty      (dirty)
    );

    gs_scan_seq #(
        .DISP_ROWS     (DISP_ROWS),
        .BYTES_PER_ROW (BYTES_PER_ROW),
        .HREP          (HREP),
        .VREP          (VREP),
        .ADDR_W        (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dirty      (dirty),
        .fmt_in     (fmt_sel),
        .fmt_q      (fmt_q),
        .frame_done (frame_done),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .rd_data    (mem_rd_data),
        .out_valid  (pix_valid),
        .out_ready  (pix_ready),
        .nibble     (nibble),
        .sof        (pix_sof),
        .eol        (pix_eol)
    );

    gs_grey_fmt u_fmt (
        .grey (nibble),
        .fmt  (fmt_q),
        .pix  (pix_data)
    );

endmodule

// File: rtl/gs_scan_expander_chk.sv
// Property checker for the scan-out expander, bound to the top module.
// Observes the ports plus the latched format.
module gs_scan_expander_chk #(
    parameter int DISP_ROWS     = 64,
    parameter int BYTES_PER_ROW = 64,
    parameter int ADDR_W        = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [23:0]       pix_data,
    input logic              pix_sof,
    input logic              pix_eol,
    input logic [1:0]        fmt_q
);

    localparam logic [ADDR_W:0] WIN_LIMIT = (ADDR_W + 1)'(DISP_ROWS * BYTES_PER_ROW);

    AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ({1'b0, mem_rd_addr} < WIN_LIMIT)); // R1

    AST_FMT24_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && fmt_q[1]) |-> ((pix_data[23:16] == pix_data[15:8])
            && (pix_data[15:8] == pix_data[7:0]) && (pix_data[7:4] == pix_data[3:0]))); // R4

    AST_FMT15_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (fmt_q == 2'd0)) |-> ((pix_data[23:15] == 9'd0)
            && (pix_data[14:10] == pix_data[4:0]) && (pix_data[9:5] == pix_data[4:0])
            && (pix_data[0] == pix_data[4]))); // R5

    AST_FMT16_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (fmt_q == 2'd1)) |-> ((pix_data[23:16] == 8'd0)
            && (pix_data[15:11] == pix_data[4:0]) && (pix_data[10:6] == pix_data[4:0])
            && (pix_data[5] == pix_data[4]) && (pix_data[0] == pix_data[4]))); // R6

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)
            && $stable(pix_sof) && $stable(pix_eol))); // R10

    AST_MARKER_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sof || pix_eol) |-> pix_valid); // R11

    AST_SOF_NOT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> !pix_eol); // R11

endmodule

bind gs_scan_expander gs_scan_expander_chk #(
    .DISP_ROWS     (DISP_ROWS),
    .BYTES_PER_ROW (BYTES_PER_ROW),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .pix_data    (pix_data),
    .pix_sof     (pix_sof),
    .pix_eol     (pix_eol),
    .fmt_q       (fmt_q)
);

// File: tb/gs_scan_expander_tb_top.sv
// Bench: behavioural memory, reference pixel queue, comparison on every accepted beat.
module gs_scan_expander_tb_top;

    localparam int DISP     = 3;
    localparam int MROWS    = 4;
    localparam int BPR      = 4;
    localparam int HR       = 4;
    localparam int VR       = 4;
    localparam int AW       = $clog2(MROWS * BPR);
    localparam int FRAME_PX = DISP * VR * BPR * 2 * HR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          invalidate = 1'b0;
    logic [1:0]    fmt_sel = 2'd2;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data = 8'd0;
    logic          pix_valid;
    logic          pix_ready = 1'b1;
    logic [23:0]   pix_data;
    logic          pix_sof;
    logic          pix_eol;

    int checks = 0;
    int failures = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    logic [7:0]  mem [MROWS * BPR];
    logic [25:0] exp_q [$];

    always #5 clk = ~clk;

    gs_scan_expander #(
        .DISP_ROWS     (DISP),
        .MEM_ROWS      (MROWS),
        .BYTES_PER_ROW (BPR),
        .HREP          (HR),
        .VREP          (VR)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .invalidate  (invalidate),
        .fmt_sel     (fmt_sel),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .pix_valid   (pix_valid),
        .pix_ready   (pix_ready),
        .pix_data    (pix_data),
        .pix_sof     (pix_sof),
        .pix_eol     (pix_eol)
    );

    // Synchronous memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pix(input int g, input int fmt);
        int n, g6, c;
        n = 2 * g + g / 8;
        if (fmt == 0) return 24'((n << 10) | (n << 5) | n);
        if (fmt == 1) begin
            g6 = (n << 1) | (n >> 4);
            return 24'((n << 11) | (g6 << 5) | n);
        end
        c = (g << 4) | g;
        return 24'((c << 16) | (c << 8) | c);
    endfunction

    task automatic build_frame(input int fmt);
        for (int r = 0; r < DISP; r++)
            for (int v = 0; v < VR; v++)
                for (int b = 0; b < BPR; b++)
                    for (int h = 0; h < 2; h++)
                        for (int k = 0; k < HR; k++) begin
                            int by, g;
                            bit s, e;
                            by = mem[r * BPR + b];
                            g  = (h == 1) ? (by & 15) : (by >> 4);
                            s  = (r == 0) && (v == 0) && (b == 0) && (h == 0) && (k == 0);
                            e  = (b == BPR - 1) && (h == 1) && (k == HR - 1);
                            exp_q.push_back({s, e, exp_pix(g, fmt)});
                        end
    endtask

    // Monitor: drive ready, then compare every beat against the reference queue
    initial begin
        bit          prev_stall = 1'b0;
        logic [25:0] prev_beat = '0;
        forever begin
            @(negedge clk);
            pix_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            if (rst_n) begin
                if (prev_stall)
                    check(pix_valid && ({pix_sof, pix_eol, pix_data} == prev_beat),
                          "R10 hold under stall", {5'd0, pix_valid, pix_sof, pix_eol, pix_data},
                          {7'd1, prev_beat});
                if (mem_rd_en)
                    check(int'(mem_rd_addr) < DISP * BPR, "R1 read window", 32'(mem_rd_addr),
                          32'(DISP * BPR - 1));
                if (pix_valid && pix_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 unexpected pixel", {6'd0, pix_sof, pix_eol, pix_data}, 32'd0);
                    end else begin
                        logic [25:0] e;
                        e = exp_q.pop_front();
                        // Order, nibbles, replication, packing, format latch, markers
                        check({pix_sof, pix_eol, pix_data} == e,
                              "R2 R3 R4 R5 R6 R7 R11 pixel",
                              {6'd0, pix_sof, pix_eol, pix_data}, {6'd0, e});
                    end
                end
                prev_stall = pix_valid && !pix_ready;
                prev_beat  = {pix_sof, pix_eol, pix_data};
            end
        end
    end

    task automatic run_frame(input int fmt, input bit stall, input bit chg_fmt, input bit mid_inv);
        int guard;
        bit inv_done;
        fmt_sel  = 2'(fmt);
        stall_en = stall;
        build_frame(fmt);
        @(negedge clk) invalidate = 1'b1;
        @(negedge clk) invalidate = 1'b0;
        guard    = 0;
        inv_done = 1'b0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
            invalidate = 1'b0;
            if (chg_fmt && exp_q.size() < FRAME_PX) fmt_sel = 2'(fmt ^ 1);   // R7
            if (mid_inv && !inv_done && exp_q.size() <= FRAME_PX / 2) begin  // R9
                invalidate = 1'b1;
                inv_done   = 1'b1;
            end
        end
        invalidate = 1'b0;
        check(exp_q.size() == 0, "R3 frame completed", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        // R9: flag cleared, so the block stays quiet
        repeat (40) begin
            @(negedge clk);
            #2;
            check(!pix_valid && !mem_rd_en, "R9 idle after frame", {30'd0, pix_valid, mem_rd_en}, 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < MROWS * BPR; i++)
            mem[i] = (i < DISP * BPR) ? {4'(i), ~4'(i)} : 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: quiet after reset with no request
        repeat (20) begin
            @(negedge clk);
            #2;
            check(!pix_valid && !mem_rd_en && !pix_sof && !pix_eol, "R8 reset quiet",
                  {28'd0, pix_valid, mem_rd_en, pix_sof, pix_eol}, 32'd0);
        end
        run_frame(2, 1'b0, 1'b0, 1'b0);   // R4 24-bit, no stalls
        run_frame(0, 1'b1, 1'b0, 1'b0);   // R5 15-bit, with stalls (R10)
        run_frame(1, 1'b1, 1'b1, 1'b0);   // R6 16-bit, format changed mid-frame (R7)
        run_frame(3, 1'b1, 1'b0, 1'b1);   // R4 code 3, request mid-frame (R9)
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule